// File: doc/BRIEF.md
# Sequential Non-Restoring Integer Square Root

This unit takes an unsigned radicand and works out both its integer square root and the exact remainder, one root bit per clock. It uses a single adder/subtractor. Each step shifts the partial remainder up by two places and brings in the next two radicand bits. It then either subtracts or adds a term built from the partial root: the sign of the running remainder picks which. The remainder is never restored between steps, and every root bit it produces is already final.

After the last root bit, one more cycle corrects a negative remainder so that the reported value is exact and non-negative. A caller presents the radicand together with a one-cycle start strobe while the unit is idle. It then waits for the done pulse and reads the root and remainder, which stay unchanged until the next accepted start.

Top module: `isqrt_nr`

## Requirements
- R1: After synchronous reset, busy, done, root and remainder outputs are all zero.
- R2: A start seen while busy is low loads the radicand. Busy is then high for exactly ROOT_W+1 consecutive cycles: ROOT_W steps plus one correction cycle, with ROOT_W = RAD_W/2 (17 cycles at the default 32-bit radicand).
- R3: Done is high for exactly one cycle, in the first cycle after busy falls, and never while busy is high.
- R4: The root output equals the largest integer r with r*r not above the radicand.
- R5: The remainder output equals radicand minus root squared. It lies in 0..2*root and fits in ROOT_W+1 bits.
- R6: A start raised while busy is high is ignored: the running computation, its length and its result are unchanged.
- R7: While busy is low and no start is given, root and remainder hold their values.
- R8: Edge radicands are exact: zero gives 0 and 0, and the all-ones value gives root 2^ROOT_W-1 with remainder 2^(ROOT_W+1)-2, which uses the remainder's top bit.
- R9: A start given in the same cycle as done is accepted, so back-to-back operations need no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Load strobe, honoured only while busy is low |
| radicand | input | RAD_W | Unsigned value whose root is wanted |
| busy | output | 1 | High while a computation is running |
| done | output | 1 | One-cycle pulse when results are valid |
| root | output | RAD_W/2 | Integer square root |
| rem | output | RAD_W/2+1 | Exact remainder, radicand minus root squared |

## Verification
A 12-bit configuration is swept over every radicand. This covers every pattern of add and subtract choices the 6-step recurrence can take, including all perfect squares (remainder zero) and every value just below a square (remainder 2*root). The default 32-bit configuration is run on zero, one, all ones, 65535 squared, powers of four and their neighbours, a fixed 0xB97973EF pattern and a pseudo-random series. These separate a wrong last-bit correction from a wrong step sign. A start injected mid-computation and a start issued in the done cycle show whether the control sequencing ignores or accepts the strobe as specified.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;

    localparam int DEF_RAD_W = 32;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ITER = 2'd1,
        PH_FIX  = 2'd2
    } phase_e;

    typedef struct packed {
        logic load;
        logic step;
        logic fix;
    } ctl_t;

    function automatic int root_width(input int rad_w);
        return rad_w / 2;
    endfunction

    function automatic int rem_reg_width(input int rad_w);
        return rad_w / 2 + 2;
    endfunction

endpackage

// File: rtl/isqrt_ctrl.sv
module isqrt_ctrl
    import isqrt_pkg::*;
#(
    parameter int STEPS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output ctl_t ctl,
    output logic busy,
    output logic done
);
    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;

    phase_e             phase;
    logic [CNT_W-1:0]   cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_ITER;
                        cnt   <= CNT_W'(STEPS - 1);
                    end
                end
                PH_ITER: begin
                    if (cnt == '0) phase <= PH_FIX;
                    else           cnt   <= cnt - 1'b1;
                end
                PH_FIX: begin
                    phase <= PH_IDLE;
                    done  <= 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl.load = (phase == PH_IDLE) && start;
        ctl.step = (phase == PH_ITER);
        ctl.fix  = (phase == PH_FIX);
        busy     = (phase != PH_IDLE);
    end

    // R2
    cnt_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ITER && cnt != '0) |=> (phase == PH_ITER && cnt == $past(cnt) - 1'b1));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    done_after_fix_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(phase) == PH_FIX && !busy));

    // R6
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ITER && start) |=> busy);

endmodule

// File: rtl/isqrt_addsub.sv
module isqrt_addsub #(
    parameter int ROOT_W = 16,
    localparam int REM_W = ROOT_W + 2
) (
    input  logic [REM_W-1:0]  rem_in,
    input  logic [1:0]        pair,
    input  logic [ROOT_W-1:0] q_in,
    output logic [REM_W-1:0]  rem_out,
    output logic              bit_out
);
    logic              neg;
    logic [REM_W-1:0]  shifted;
    logic [REM_W-1:0]  opnd;

    always_comb begin
        neg     = rem_in[REM_W-1];
        shifted = {rem_in[REM_W-3:0], pair};
        // negative: append 11 and add; non-negative: append 01 and subtract
        opnd    = {q_in, neg, 1'b1};
        rem_out = neg ? (shifted + opnd) : (shifted - opnd);
        bit_out = ~rem_out[REM_W-1];
    end
endmodule

// File: rtl/isqrt_datapath.sv
module isqrt_datapath
    import isqrt_pkg::*;
#(
    parameter int RAD_W = 32,
    localparam int ROOT_W = RAD_W / 2,
    localparam int REM_W  = ROOT_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic [RAD_W-1:0]  rad_i,
    output logic [ROOT_W-1:0] root_o,
    output logic [ROOT_W:0]   rem_o
);
    logic [RAD_W-1:0]  d_r;
    logic [ROOT_W-1:0] q_r;
    logic [REM_W-1:0]  r_r;
    logic [REM_W-1:0]  step_rem;
    logic              step_bit;

    isqrt_addsub #(.ROOT_W(ROOT_W)) i_addsub (
        .rem_in (r_r),
        .pair   (d_r[RAD_W-1 -: 2]),
        .q_in   (q_r),
        .rem_out(step_rem),
        .bit_out(step_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            d_r <= '0;
            q_r <= '0;
            r_r <= '0;
        end else if (ctl.load) begin
            d_r <= rad_i;
            q_r <= '0;
            r_r <= '0;
        end else if (ctl.step) begin
            d_r <= {d_r[RAD_W-3:0], 2'b00};
            r_r <= step_rem;
            q_r <= {q_r[ROOT_W-2:0], step_bit};
        end else if (ctl.fix) begin
            if (r_r[REM_W-1]) r_r <= r_r + {1'b0, q_r, 1'b1};
        end
    end

    assign root_o = q_r;
    assign rem_o  = r_r[ROOT_W:0];

    // R5
    fix_nonneg_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.fix |=> !r_r[REM_W-1]);

endmodule

// File: rtl/isqrt_nr.sv
module isqrt_nr
    import isqrt_pkg::*;
#(
    parameter int RAD_W = DEF_RAD_W,
    localparam int ROOT_W = root_width(RAD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [RAD_W-1:0]  radicand,
    output logic              busy,
    output logic              done,
    output logic [ROOT_W-1:0] root,
    output logic [ROOT_W:0]   rem
);
    ctl_t ctl;

    isqrt_ctrl #(.STEPS(ROOT_W)) i_ctrl (
        .clk  (clk),
        .rst  (rst),
        .start(start),
        .ctl  (ctl),
        .busy (busy),
        .done (done)
    );

    isqrt_datapath #(.RAD_W(RAD_W)) i_dp (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .rad_i (radicand),
        .root_o(root),
        .rem_o (rem)
    );

    // R5
    rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ({1'b0, rem} <= {root, 2'b00} >> 1));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(root) && $stable(rem)));

    // R3
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

endmodule

// File: tb/test_isqrt_nr.sv
module test_isqrt_nr;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // default 32-bit instance
    logic        start_b = 1'b0;
    logic [31:0] rad_b   = '0;
    logic        busy_b, done_b;
    logic [15:0] root_b;
    logic [16:0] rem_b;

    isqrt_nr i_isqrt_nr (
        .clk(clk), .rst(rst), .start(start_b), .radicand(rad_b),
        .busy(busy_b), .done(done_b), .root(root_b), .rem(rem_b)
    );

    // small instance for exhaustive sweep
    logic          start_s = 1'b0;
    logic [SW-1:0] rad_s   = '0;
    logic          busy_s, done_s;
    logic [SW/2-1:0] root_s;
    logic [SW/2:0]   rem_s;

    isqrt_nr #(.RAD_W(SW)) i_isqrt_nr_small (
        .clk(clk), .rst(rst), .start(start_s), .radicand(rad_s),
        .busy(busy_s), .done(done_s), .root(root_s), .rem(rem_s)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint isqrt_ref(input longint d);
        longint r = longint'($sqrt(real'(d)));
        while (r * r > d) r--;
        while ((r + 1) * (r + 1) <= d) r++;
        return r;
    endfunction

    // drive start at the current negedge, then wait until busy falls
    task automatic big_run(input logic [31:0] d, input bit inject);
        int n = 0;
        longint er, em;
        rad_b = d; start_b = 1'b1;
        @(negedge clk);
        start_b = 1'b0;
        while (busy_b && n < 100) begin
            n++;
            if (inject && n == 5) begin start_b = 1'b1; rad_b = ~d; end
            else start_b = 1'b0;
            check(!done_b, "R3 done while busy", done_b, 0);
            @(negedge clk);
        end
        start_b = 1'b0;
        er = isqrt_ref(longint'(d));
        em = longint'(d) - er * er;
        check(n == 17, inject ? "R6 busy length" : "R2 busy length", n, 17);
        check(done_b == 1'b1, "R3 done pulse", done_b, 1);
        check(longint'(root_b) == er, inject ? "R6 root" : "R4 root", root_b, er);
        check(longint'(rem_b) == em, inject ? "R6 rem" : "R5 rem", rem_b, em);
    endtask

    task automatic small_run(input int d);
        int n = 0;
        int er = 0;
        rad_s = SW'(d); start_s = 1'b1;
        @(negedge clk);
        start_s = 1'b0;
        while (busy_s && n < 100) begin n++; @(negedge clk); end
        while ((er + 1) * (er + 1) <= d) er++;
        check(n == SW/2 + 1 && done_s, "R2 small busy/done", n, SW/2 + 1);
        check(int'(root_s) == er, "R4 small root", root_s, er);
        check(int'(rem_s) == d - er * er && int'(rem_s) <= 2 * er, "R5 small rem", rem_s, d - er * er);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] lcg;
        logic [15:0] hr;
        logic [16:0] hm;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy_b && !done_b && root_b == 0 && rem_b == 0, "R1 reset", {busy_b, done_b, root_b}, 0);
        check(!busy_s && !done_s && root_s == 0 && rem_s == 0, "R1 reset small", root_s, 0);
        rst = 1'b0;
        @(negedge clk);

        // R8 edge radicands
        big_run(32'h0, 1'b0);
        check(root_b == 0 && rem_b == 0, "R8 zero", root_b, 0);
        @(negedge clk);
        big_run(32'hFFFF_FFFF, 1'b0);
        check(root_b == 16'hFFFF && rem_b == 17'd131070, "R8 all ones rem", rem_b, 131070);
        @(negedge clk);
        check(!done_b, "R3 done falls", done_b, 0);

        // R7 hold while idle
        hr = root_b; hm = rem_b;
        rad_b = 32'h1234_5678;
        repeat (4) @(negedge clk);
        check(root_b == hr && rem_b == hm, "R7 hold root/rem", rem_b, hm);

        big_run(32'd1, 1'b0);  @(negedge clk);
        big_run(32'd2, 1'b0);  @(negedge clk);
        big_run(32'd3, 1'b0);  @(negedge clk);
        big_run(32'd4, 1'b0);  @(negedge clk);
        big_run(32'h7F, 1'b0); @(negedge clk);
        big_run(32'hB979_73EF, 1'b0);
        check(root_b == 16'hD9E7, "R4 fixed pattern", root_b, 16'hD9E7);
        @(negedge clk);
        big_run(32'hFFFE_0001, 1'b0); @(negedge clk);
        big_run(32'hFFFE_0000, 1'b0); @(negedge clk);
        big_run(32'h4000_0000, 1'b0); @(negedge clk);
        big_run(32'h3FFF_FFFF, 1'b0); @(negedge clk);

        // R6 start while busy ignored
        big_run(32'hA5A5_1234, 1'b1); @(negedge clk);

        // R9 back-to-back: start in the done cycle
        big_run(32'h0001_0000, 1'b0);
        big_run(32'h00FF_FFFF, 1'b0);
        check(root_b == 16'h0FFF, "R9 back-to-back root", root_b, 16'h0FFF);
        @(negedge clk);

        lcg = 32'h1357_9BDF;
        for (int i = 0; i < 24; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            big_run(lcg, 1'b0);
            @(negedge clk);
        end

        // exhaustive sweep of the small configuration
        for (int v = 0; v < (1 << SW); v++) begin
            small_run(v);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule